// File: doc/BRIEF.md
# Region-Based Memory Access Checker

This block sits next to a processor that has a single bus, and it rules on every access the processor makes. Instruction fetches and data accesses are treated alike. The rule comes from eight programmable address regions, each with its own base, size, enable and permission code. Behind them is a background default, and in front of them are two fixed system windows that always pass while the checker is on. The processor presents an address, a privilege flag and a write flag. In the same cycle the block returns a combinational allow decision. One clock later it returns a registered fault pulse for each access it denied.

Software sets up the block through a small word-addressed register bank. The bank holds an identification word, a control word, a region selector, and a base register and an attribute register. The base and attribute registers both act on the region the selector names. When regions overlap, the region with the highest number decides. While the global enable is clear, everything passes.

Top module: `region_guard`

## Requirements
- R1: While control bit 0 (enable) is 0, every access is allowed and no fault is raised, whatever the region settings.
- R2: While enabled, accesses to the vector window (addresses 0x0000_0000 to 0x0000_00FF) and the system-control window (0xE000_E000 to 0xE000_EFFF) are always allowed, for any privilege and direction.
- R3: Permission code 00 denies privileged and unprivileged accesses alike.
- R4: Permission code 01 allows privileged reads and writes and denies every unprivileged access.
- R5: Permission code 10 allows privileged reads and writes and unprivileged reads, and denies unprivileged writes.
- R6: Permission code 11 allows every access, exactly as if the checker were absent.
- R7: When an address lies in several enabled regions, the permission of the highest-numbered one applies.
- R8: A size code k (attribute bits 5:1) gives a region of 2^(k+8) bytes. Codes 24 and above cover the whole 4 GB space. Only address bits above the region size are compared, and base bits 7:0 always read back as 0.
- R9: A region whose enable (attribute bit 0) is 0 never matches.
- R10: An enabled access outside every window and region is allowed only when it is privileged and control bit 2 (background enable) is 1. Otherwise it is denied.
- R11: acc_fault is high for exactly the one cycle after a cycle in which acc_valid was high and acc_allow low, and is low otherwise.
- R12: Register word offsets: 0 identification (read-only, region count in bits 15:8), 1 control, 2 region select, 3 region base, 4 region attributes (permission in bits 9:8). Offsets 3 and 4 act on the selected region. A select value at or above the region count is ignored, and so are writes to offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Register write when 1, read when 0 |
| bus_addr | input | 3 | Register word offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| acc_valid | input | 1 | Processor access present this cycle |
| acc_addr | input | 32 | Access address |
| acc_priv | input | 1 | Access is privileged |
| acc_write | input | 1 | Access is a write |
| acc_allow | output | 1 | Combinational allow decision |
| acc_fault | output | 1 | Registered one-cycle pulse for a denied access |

## Verification
The allow decision is due in the same cycle the access is presented. The fault pulse is due after the next rising edge, and a register write takes effect at the edge that accepts it. The bench changes inputs on the falling edge and pushes the expected allow and fault for each access into a queue. A monitor samples one time unit after the following rising edge, where the allow for the held inputs and the fault registered at that edge are both settled. It checks the two together and then confirms on the next idle cycle that the pulse has dropped. Register reads are combinational, so they are compared during the cycle in which they are issued.

// File: rtl/region_guard_pkg.sv
package region_guard_pkg;

   localparam int MIN_LOG2   = 8;   // smallest region: 256 bytes
   localparam int CODE_W     = 5;
   localparam int OFF_W      = 3;

   localparam logic [OFF_W-1:0] OFF_ID   = 3'd0;
   localparam logic [OFF_W-1:0] OFF_CTRL = 3'd1;
   localparam logic [OFF_W-1:0] OFF_SEL  = 3'd2;
   localparam logic [OFF_W-1:0] OFF_BASE = 3'd3;
   localparam logic [OFF_W-1:0] OFF_ATTR = 3'd4;

   typedef enum logic [1:0] {
      PERM_NONE = 2'b00,
      PERM_PRIV = 2'b01,
      PERM_URO  = 2'b10,
      PERM_FULL = 2'b11
   } perm_e;

   typedef struct packed {
      logic              en;
      logic [CODE_W-1:0] size_code;
      perm_e             perm;
   } region_attr_t;

endpackage

// File: rtl/region_guard_regs.sv
module region_guard_regs
   import region_guard_pkg::*;
#(
   parameter int NREG  = 8,
   parameter int AW    = 32,
   parameter int DW    = 32,
   localparam int SEL_W = $clog2(NREG)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         bus_sel,
   input  logic                         bus_we,
   input  logic [OFF_W-1:0]             bus_addr,
   input  logic [DW-1:0]                bus_wdata,
   output logic [DW-1:0]                bus_rdata,
   output logic                         enable_o,
   output logic                         bg_en_o,
   output logic [NREG-1:0][AW-1:0]      base_o,
   output region_attr_t [NREG-1:0]      attr_o
);

   logic             enable_q, bg_en_q;
   logic [SEL_W-1:0] sel_q;
   logic             wr;

   assign wr = bus_sel & bus_we;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         enable_q <= 1'b0;
         bg_en_q  <= 1'b0;
         sel_q    <= '0;
      end else if (wr) begin
         if (bus_addr == OFF_CTRL) begin
            enable_q <= bus_wdata[0];
            bg_en_q  <= bus_wdata[2];
         end
         if (bus_addr == OFF_SEL && bus_wdata < DW'(NREG))
            sel_q <= bus_wdata[SEL_W-1:0];
      end
   end

   for (genvar g = 0; g < NREG; g++) begin : g_region
      logic [AW-1:0] base_q;
      region_attr_t  attr_q;
      logic          hit_sel;

      assign hit_sel = wr && (sel_q == SEL_W'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            base_q <= '0;
            attr_q <= '{en: 1'b0, size_code: '0, perm: PERM_NONE};
         end else if (hit_sel) begin
            if (bus_addr == OFF_BASE)
               base_q <= {bus_wdata[AW-1:MIN_LOG2], {MIN_LOG2{1'b0}}};
            if (bus_addr == OFF_ATTR)
               attr_q <= '{en: bus_wdata[0],
                           size_code: bus_wdata[CODE_W:1],
                           perm: perm_e'(bus_wdata[9:8])};
         end
      end

      assign base_o[g] = base_q;
      assign attr_o[g] = attr_q;
   end

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         OFF_ID:   bus_rdata[15:8] = 8'(NREG);
         OFF_CTRL: bus_rdata = {{(DW-3){1'b0}}, bg_en_q, 1'b0, enable_q};
         OFF_SEL:  bus_rdata = DW'(sel_q);
         OFF_BASE: bus_rdata = DW'(base_o[sel_q]);
         OFF_ATTR: bus_rdata = {{(DW-10){1'b0}}, attr_o[sel_q].perm, 2'b00,
                                attr_o[sel_q].size_code, attr_o[sel_q].en};
         default:  bus_rdata = '0;
      endcase
   end

   assign enable_o = enable_q;
   assign bg_en_o  = bg_en_q;

   assert_sel_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr && bus_addr == OFF_SEL) |=> $stable(sel_q));

   assert_sel_range_R12: assert property (@(posedge clk) disable iff (!rst_n)
      32'(sel_q) < NREG);

endmodule

// File: rtl/region_guard_match.sv
module region_guard_match
   import region_guard_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic [AW-1:0] addr,
   input  logic [AW-1:0] base,
   input  region_attr_t  attr,
   output logic          hit
);

   localparam int SH_W = $clog2(AW + 1) + 1;

   logic [SH_W-1:0] shamt;
   logic [AW-1:0]   mask;

   always_comb begin
      shamt = SH_W'(attr.size_code) + SH_W'(MIN_LOG2);
      if (shamt >= SH_W'(AW))
         mask = '0;
      else
         mask = {AW{1'b1}} << shamt;
   end

   assign hit = attr.en && (((addr ^ base) & mask) == '0);

endmodule

// File: rtl/region_guard_resolve.sv
module region_guard_resolve
   import region_guard_pkg::*;
#(
   parameter int            NREG     = 8,
   parameter int            AW       = 32,
   parameter logic [AW-1:0] VT_BASE  = '0,
   parameter int            VT_LOG2  = 8,
   parameter logic [AW-1:0] SYS_BASE = AW'(32'hE000_E000),
   parameter int            SYS_LOG2 = 12
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    enable,
   input  logic                    bg_en,
   input  logic [NREG-1:0]         hit,
   input  region_attr_t [NREG-1:0] attr,
   input  logic [AW-1:0]           addr,
   input  logic                    priv,
   input  logic                    write,
   output logic                    allow
);

   localparam int NWIN = 2;
   localparam logic [NWIN-1:0][AW-1:0] WIN_BASE = {SYS_BASE, VT_BASE};
   localparam int WIN_LOG2 [NWIN] = '{VT_LOG2, SYS_LOG2};

   logic [NWIN-1:0] in_win_v;
   logic            in_win;
   logic [NREG-1:0] win;
   logic            any_hit;
   perm_e           perm_sel;
   logic            perm_ok;

   for (genvar w = 0; w < NWIN; w++) begin : g_win
      assign in_win_v[w] = (addr >> WIN_LOG2[w]) == (WIN_BASE[w] >> WIN_LOG2[w]);
   end
   assign in_win = |in_win_v;

   // a region wins when no higher-numbered region also hits
   for (genvar g = 0; g < NREG; g++) begin : g_prio
      if (g == NREG - 1) begin : g_top
         assign win[g] = hit[g];
      end else begin : g_low
         assign win[g] = hit[g] & ~(|hit[NREG-1:g+1]);
      end
   end
   assign any_hit = |hit;

   always_comb begin
      perm_sel = PERM_NONE;
      for (int i = 0; i < NREG; i++)
         if (win[i]) perm_sel = perm_e'(perm_sel | attr[i].perm);
   end

   always_comb begin
      unique case (perm_sel)
         PERM_NONE: perm_ok = 1'b0;
         PERM_PRIV: perm_ok = priv;
         PERM_URO:  perm_ok = priv | ~write;
         PERM_FULL: perm_ok = 1'b1;
         default:   perm_ok = 1'b0;
      endcase
   end

   assign allow = !enable || in_win || (any_hit ? perm_ok : (priv && bg_en));

   assert_single_winner_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(win));

   assert_off_allows_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |-> allow);

   assert_window_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && in_win) |-> allow);

   assert_bg_unpriv_deny_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !in_win && !any_hit && !priv) |-> !allow);

endmodule

// File: rtl/region_guard.sv
module region_guard
   import region_guard_pkg::*;
#(
   parameter int            NREG     = 8,
   parameter int            AW       = 32,
   parameter int            DW       = 32,
   parameter logic [AW-1:0] VT_BASE  = '0,
   parameter int            VT_LOG2  = 8,
   parameter logic [AW-1:0] SYS_BASE = AW'(32'hE000_E000),
   parameter int            SYS_LOG2 = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_sel,
   input  logic             bus_we,
   input  logic [OFF_W-1:0] bus_addr,
   input  logic [DW-1:0]    bus_wdata,
   output logic [DW-1:0]    bus_rdata,
   input  logic             acc_valid,
   input  logic [AW-1:0]    acc_addr,
   input  logic             acc_priv,
   input  logic             acc_write,
   output logic             acc_allow,
   output logic             acc_fault
);

   if (NREG < 2 || NREG > 16) begin : g_bad_nreg
      $error("region_guard: NREG must lie in 2..16");
   end
   if (AW < 16 || AW > DW) begin : g_bad_aw
      $error("region_guard: AW must lie in 16..DW");
   end
   if (DW != 32) begin : g_bad_dw
      $error("region_guard: DW must be 32");
   end
   if (VT_LOG2 < MIN_LOG2 || SYS_LOG2 < MIN_LOG2 || VT_LOG2 >= AW || SYS_LOG2 >= AW) begin : g_bad_win
      $error("region_guard: window sizes out of range");
   end

   logic                    enable, bg_en;
   logic [NREG-1:0][AW-1:0] base;
   region_attr_t [NREG-1:0] attr;
   logic [NREG-1:0]         hit;
   logic                    fault_q;

   region_guard_regs #(.NREG(NREG), .AW(AW), .DW(DW)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .enable_o  (enable),
      .bg_en_o   (bg_en),
      .base_o    (base),
      .attr_o    (attr)
   );

   for (genvar g = 0; g < NREG; g++) begin : g_match
      region_guard_match #(.AW(AW)) u_match (
         .addr (acc_addr),
         .base (base[g]),
         .attr (attr[g]),
         .hit  (hit[g])
      );
   end

   region_guard_resolve #(
      .NREG(NREG), .AW(AW), .VT_BASE(VT_BASE), .VT_LOG2(VT_LOG2),
      .SYS_BASE(SYS_BASE), .SYS_LOG2(SYS_LOG2)
   ) u_resolve (
      .clk    (clk),
      .rst_n  (rst_n),
      .enable (enable),
      .bg_en  (bg_en),
      .hit    (hit),
      .attr   (attr),
      .addr   (acc_addr),
      .priv   (acc_priv),
      .write  (acc_write),
      .allow  (acc_allow)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) fault_q <= 1'b0;
      else        fault_q <= acc_valid & ~acc_allow;
   end
   assign acc_fault = fault_q;

   assert_fault_after_deny_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_allow) |=> acc_fault);

   assert_fault_has_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
      acc_fault |-> $past(acc_valid && !acc_allow));

endmodule

// File: tb/region_guard_tb.sv
module region_guard_tb;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_we = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        acc_valid = 1'b0;
   logic [31:0] acc_addr = '0;
   logic        acc_priv = 1'b0, acc_write = 1'b0;
   logic        acc_allow, acc_fault;

   int checks = 0;
   int errors = 0;

   typedef struct {
      logic  allow;
      logic  fault;
      string tag;
   } item_t;
   item_t sb_q[$];

   // shadow configuration written by the bench
   logic        sh_enable = 1'b0, sh_bg = 1'b0;
   logic [31:0] sh_base [8];
   logic        sh_en   [8];
   int          sh_code [8];
   logic [1:0]  sh_perm [8];

   always #(CLK_PERIOD/2) clk = ~clk;

   region_guard u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_priv(acc_priv),
      .acc_write(acc_write), .acc_allow(acc_allow), .acc_fault(acc_fault)
   );

   task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic model_allow(logic [31:0] a, logic p, logic w);
      if (!sh_enable) return 1'b1;
      if (a[31:8] == 24'h0 || a[31:12] == 20'hE000E) return 1'b1;
      for (int i = 7; i >= 0; i--) begin
         if (sh_en[i] && (sh_code[i] >= 24 || ((a ^ sh_base[i]) >> (sh_code[i] + 8)) == 0)) begin
            case (sh_perm[i])
               2'b00:   return 1'b0;
               2'b01:   return p;
               2'b10:   return p | ~w;
               default: return 1'b1;
            endcase
         end
      end
      return p & sh_bg;
   endfunction

   task automatic bus_write(input logic [2:0] off, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = off; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic bus_read(input logic [2:0] off, input logic [31:0] exp, input string tag);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = off;
      #1;
      chk(bus_rdata === exp, tag, bus_rdata, exp);
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic set_ctrl(input logic en, input logic bg);
      bus_write(3'd1, {29'd0, bg, 1'b0, en});
      sh_enable = en; sh_bg = bg;
   endtask

   task automatic set_region(input int idx, input logic [31:0] b, input logic en,
                             input int code, input logic [1:0] perm);
      bus_write(3'd2, 32'(idx));
      bus_write(3'd3, b);
      bus_write(3'd4, {22'd0, perm, 2'b00, 5'(code), en});
      sh_base[idx] = {b[31:8], 8'h00};
      sh_en[idx] = en; sh_code[idx] = code; sh_perm[idx] = perm;
   endtask

   // driver: present one access for one cycle, then one idle cycle
   task automatic access(input logic [31:0] a, input logic p, input logic w,
                         input logic exp_allow, input string tag);
      item_t it;
      @(negedge clk);
      acc_valid = 1'b1; acc_addr = a; acc_priv = p; acc_write = w;
      it.allow = exp_allow;
      it.fault = ~exp_allow;
      it.tag   = tag;
      chk(model_allow(a, p, w) === exp_allow, {tag, " (model)"}, 32'(model_allow(a, p, w)), 32'(exp_allow));
      sb_q.push_back(it);
      @(negedge clk);
      acc_valid = 1'b0;
      @(negedge clk);
   endtask

   // monitor: compare once the edge after presentation has settled
   logic had_access = 1'b0;
   always begin
      @(posedge clk);
      #1;
      if (acc_valid) begin
         if (sb_q.size() == 0) begin
            chk(1'b0, "scoreboard empty", 32'd0, 32'd1);
         end else begin
            item_t it;
            it = sb_q.pop_front();
            chk(acc_allow === it.allow, {it.tag, " allow"}, 32'(acc_allow), 32'(it.allow));
            chk(acc_fault === it.fault, {it.tag, " fault R11"}, 32'(acc_fault), 32'(it.fault));
         end
         had_access = 1'b1;
      end else if (had_access) begin
         chk(acc_fault === 1'b0, "R11 fault drops after one cycle", 32'(acc_fault), 32'd0);
         had_access = 1'b0;
      end
   end

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 8; i++) begin
         sh_base[i] = '0; sh_en[i] = 1'b0; sh_code[i] = 0; sh_perm[i] = 2'b00;
      end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      chk(acc_fault === 1'b0, "reset fault low R11", 32'(acc_fault), 32'd0);
      bus_read(3'd1, 32'h0, "R12 reset control");
      bus_read(3'd0, 32'h0000_0800, "R12 identification");
      bus_write(3'd0, 32'hFFFF_FFFF);
      bus_read(3'd0, 32'h0000_0800, "R12 identification write ignored");

      // disabled: everything passes
      set_region(0, 32'h2000_0000, 1'b1, 4, 2'b00);
      access(32'h2000_0010, 1'b0, 1'b1, 1'b1, "R1 disabled unpriv write");
      access(32'h9000_0000, 1'b1, 1'b0, 1'b1, "R1 disabled priv read");

      // enabled, background off
      set_region(0, 32'h2000_0000, 1'b1, 4, 2'b01);
      set_ctrl(1'b1, 1'b0);
      access(32'h3000_0000, 1'b1, 1'b0, 1'b0, "R10 priv unmatched bg off");
      access(32'h3000_0000, 1'b0, 1'b0, 1'b0, "R10 unpriv unmatched bg off");
      set_ctrl(1'b1, 1'b1);
      access(32'h3000_0000, 1'b1, 1'b1, 1'b1, "R10 priv unmatched bg on");
      access(32'h3000_0000, 1'b0, 1'b0, 1'b0, "R10 unpriv unmatched bg on");

      // fixed windows
      access(32'h0000_0010, 1'b0, 1'b1, 1'b1, "R2 vector window unpriv write");
      access(32'hE000_ED94, 1'b0, 1'b0, 1'b1, "R2 system window unpriv read");
      access(32'hE000_F000, 1'b0, 1'b0, 1'b0, "R2 just past system window");

      // region 0 privileged only
      access(32'h2000_0100, 1'b0, 1'b0, 1'b0, "R4 unpriv read denied");
      access(32'h2000_0100, 1'b1, 1'b1, 1'b1, "R4 priv write allowed");
      access(32'h2000_1000, 1'b0, 1'b0, 1'b0, "R8 just past 4KB region");

      // region 1 overlaps region 0 upper half with full access
      set_region(1, 32'h2000_0800, 1'b1, 3, 2'b11);
      access(32'h2000_0900, 1'b0, 1'b1, 1'b1, "R7 higher region wins");
      access(32'h2000_0100, 1'b0, 1'b0, 1'b0, "R7 lower half keeps region 0");
      access(32'h2000_0FFC, 1'b0, 1'b1, 1'b1, "R6 full access unpriv write");

      // region 2 unprivileged read-only
      set_region(2, 32'h4000_0000, 1'b1, 8, 2'b10);
      access(32'h4000_FF00, 1'b0, 1'b0, 1'b1, "R5 unpriv read");
      access(32'h4000_FF00, 1'b0, 1'b1, 1'b0, "R5 unpriv write denied");
      access(32'h4000_0004, 1'b1, 1'b1, 1'b1, "R5 priv write");

      // region 3 no access, smallest size
      set_region(3, 32'h6000_0000, 1'b1, 0, 2'b00);
      access(32'h6000_00FC, 1'b1, 1'b0, 1'b0, "R3 priv denied");
      access(32'h6000_0000, 1'b0, 1'b0, 1'b0, "R3 unpriv denied");
      access(32'h6000_0100, 1'b1, 1'b0, 1'b1, "R8 256B region ends");

      // unaligned base is truncated to its size
      set_region(4, 32'h4000_1234, 1'b1, 4, 2'b00);
      bus_read(3'd3, 32'h4000_1200, "R8 base low bits read zero");
      bus_read(3'd4, 32'h0000_0009, "R12 attribute readback");
      access(32'h4000_1010, 1'b1, 1'b0, 1'b0, "R8 aligned match below base");
      access(32'h4000_2000, 1'b0, 1'b0, 1'b1, "R8 past region falls to region 2");

      // whole-space region, highest number
      set_region(7, 32'h0000_0000, 1'b1, 24, 2'b11);
      access(32'h6000_0000, 1'b0, 1'b1, 1'b1, "R7 region 7 over region 3");
      access(32'h3000_0000, 1'b0, 1'b1, 1'b1, "R8 4GB region covers all");
      set_region(7, 32'h0000_0000, 1'b0, 24, 2'b11);
      access(32'h6000_0000, 1'b1, 1'b0, 1'b0, "R9 disabled region ignored");

      // select register
      bus_write(3'd2, 32'd9);
      bus_read(3'd2, 32'd7, "R12 out-of-range select ignored");
      bus_write(3'd2, 32'd1);
      bus_read(3'd3, 32'h2000_0800, "R12 base of selected region");

      // disable again
      set_ctrl(1'b0, 1'b1);
      access(32'h6000_0000, 1'b0, 1'b1, 1'b1, "R1 disabled after use");

      repeat (3) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule